// File: doc/BRIEF.md
# Thermal-Balancing Duty Reference Corrector

This block sits between the outer current regulator of a set of four paralleled converter modules and their four inner current-sharing loops. Each input sample carries one common duty reference `m` and one temperature reading per module. The block forms the mean temperature of the healthy modules. For each module it runs a slow proportional-integral regulator on the difference between that mean and the module's own reading, and it adds the result to `m`. The four sums go out as per-module duty references. A module that runs hot gets a lower reference and a cool one gets a higher reference. Because every error is taken against the same mean, the corrections cancel and the total output current stays where the outer loop put it.

Temperature readings are raw unsigned integers at one count per kelvin and are used as-is. Duty values are unsigned Q1.15: 0 is 0 % and 0x8000 is 100 %. A module flagged as faulted is removed from the mean. Its correction and integrator are forced to zero. The regulator coefficients are integers in duty LSB per kelvin, so the correction changes only a little per sample. The caller sets how slow the thermal loop is through the sample rate.

Samples arrive on a valid/ready input and results leave on a valid/ready output. An input sample is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and `out_valid` are held. `in_ready` drops only when both internal registers hold undelivered data. Back-pressure therefore stalls the regulator, which updates once per delivered result and never drops or repeats a sample.

Top module: `thermal_duty_corrector`

## Requirements
- R1: The mean is floor(sum of the non-faulted temperatures / number of non-faulted modules), or 0 when all four are faulted. Module i's error is the mean minus its own temperature. Temperature lane i is `in_temp[12*i +: 12]` and fault bit i is `in_fault[i]`, where 1 means faulted.
- R2: For a non-faulted module, the integrator candidate is the stored integrator plus KI times the error, saturated to ±0x8000. The raw output is m + KP times the error + that candidate, and the reported value is the raw output clamped (R5). Output lane i is `out_duty[16*i +: 16]`. The defaults are KP = 4 and KI = 1.
- R3: When the active temperature sum divides evenly by the active count, no module is faulted and no lane clamps, the four output lanes sum to exactly four times m.
- R4: A faulted module outputs min(m, 0x8000) and its integrator is cleared, so it restarts from zero when the fault flag is removed.
- R5: Every output lane is clamped to the range 0 to 0x8000, and an input m above 0x8000 is treated as 0x8000 at the output.
- R6: When a lane's raw output falls outside 0 to 0x8000, that lane's integrator keeps its previous value (anti-windup).
- R7: While `out_valid` is high and `out_ready` is low, `out_duty` and `out_valid` stay unchanged. Results are delivered in input order with none lost or repeated.
- R8: With `out_ready` held high, a sample accepted at clock edge k appears with `out_valid` high after edge k+1, and all four lanes change on that same edge.
- R9: After reset `out_valid` is 0, `out_duty` is 0, `in_ready` is 1 and every integrator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this edge |
| in_duty | input | 16 | Common duty reference m, Q1.15 |
| in_temp | input | 48 | Four 12-bit temperatures, lane 0 in the low bits |
| in_fault | input | 4 | Per-module fault flag, 1 = excluded |
| out_valid | output | 1 | Corrected references present |
| out_ready | input | 1 | Downstream takes the result this edge |
| out_duty | output | 64 | Four 16-bit Q1.15 references, lane 0 in the low bits |

## Verification
Equal temperatures show that the block passes m through untouched. A fixed temperature spread sent several times shows the integrator building up, and the lane sum shows whether the corrections cancel. A sum that does not divide evenly shows whether the mean is floored, and one or two faulted modules show the division by 3 and by 2 as well as the zeroing of the faulted lane. Driving m near full scale and near zero makes lanes clamp, and a following equal-temperature sample shows whether the integrator kept moving during saturation. Random stalls on the output make the back-pressure hold and the order of results visible.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int NCH = 4;

  // Ceiling of 2^rb / d, used as a reciprocal so floor(sum/d) is exact for the sum range.
  function automatic int unsigned recip_ceil(input int d, input int rb);
    int unsigned scale;
    scale = 32'd1 << rb;
    return (scale + int'(d) - 1) / int'(d);
  endfunction
endpackage

// File: rtl/tdc_mean.sv
module tdc_mean
  import tdc_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic [NCH*TW-1:0]         temp,
  input  logic [NCH-1:0]            fault,
  output logic [NCH-1:0][TW+1:0]    err,
  output logic [NCH-1:0]            act
);
  localparam int SW   = TW + 2;
  localparam int EW   = TW + 2;
  localparam int RB   = TW + 4;
  localparam int CNTW = $clog2(NCH + 1);
  localparam int PW   = SW + RB + 1;

  logic [SW-1:0]   sum;
  logic [CNTW-1:0] cnt;
  logic [RB:0]     recip;
  logic [PW-1:0]   prod;
  logic [TW-1:0]   mean;

  always_comb begin
    sum = '0;
    cnt = '0;
    for (int i = 0; i < NCH; i++) begin
      if (!fault[i]) begin
        sum = sum + SW'(temp[i*TW +: TW]);
        cnt = cnt + CNTW'(1);
      end
    end
  end

  always_comb begin
    recip = '0;
    for (int d = 1; d <= NCH; d++) begin
      if (cnt == CNTW'(d)) recip = (RB+1)'(recip_ceil(d, RB));
    end
  end

  assign prod = PW'(sum) * PW'(recip);

  always_comb begin
    if (cnt == CNTW'(NCH)) mean = TW'(sum >> 2);
    else                   mean = TW'(prod >> RB);
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_err
      assign act[g] = ~fault[g];
      assign err[g] = fault[g] ? '0
                    : EW'($signed({2'b00, mean}) - $signed({2'b00, temp[g*TW +: TW]}));
    end
  endgenerate
endmodule

// File: rtl/tdc_pi_chan.sv
module tdc_pi_chan #(
  parameter int EW = 14,
  parameter int DW = 16,
  parameter int AW = 26,
  parameter int KP = 4,
  parameter int KI = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic                 act,
  input  logic [DW-1:0]        ref_in,
  input  logic [EW-1:0]        err,
  output logic [DW-1:0]        duty
);
  localparam logic signed [AW-1:0] ONE_A = AW'(64'd1 << (DW-1));
  localparam logic signed [AW-1:0] KP_A  = AW'(KP);
  localparam logic signed [AW-1:0] KI_A  = AW'(KI);

  logic signed [AW-1:0] integ;
  logic signed [AW-1:0] e_a, m_a, p_term, i_sum, icand, raw;
  logic                 in_rng;
  logic [DW-1:0]        raw_clip, ref_clip;

  always_comb begin
    e_a    = {{(AW-EW){err[EW-1]}}, err};
    m_a    = $signed({{(AW-DW){1'b0}}, ref_in});
    p_term = e_a * KP_A;
    i_sum  = integ + e_a * KI_A;
    if (i_sum > ONE_A)       icand = ONE_A;
    else if (i_sum < -ONE_A) icand = -ONE_A;
    else                     icand = i_sum;
    raw    = m_a + p_term + icand;
    in_rng = (raw >= 0) && (raw <= ONE_A);
    if (raw < 0)            raw_clip = '0;
    else if (raw > ONE_A)   raw_clip = DW'(ONE_A);
    else                    raw_clip = DW'(raw);
    ref_clip = (m_a > ONE_A) ? DW'(ONE_A) : ref_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ <= '0;
      duty  <= '0;
    end else if (upd) begin
      if (!act) begin
        integ <= '0;
        duty  <= ref_clip;
      end else begin
        if (in_rng) integ <= icand;
        duty <= raw_clip;
      end
    end
  end
endmodule

// File: rtl/thermal_duty_corrector.sv
module thermal_duty_corrector
  import tdc_pkg::*;
#(
  parameter int TW = 12,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int KP = 4,
  parameter int KI = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_duty,
  input  logic [NCH*TW-1:0] in_temp,
  input  logic [NCH-1:0]    in_fault,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*DW-1:0] out_duty
);
  localparam int EW = TW + 2;
  localparam int AW = EW + CW + 4;

  logic [NCH-1:0][EW-1:0] mean_err;
  logic [NCH-1:0]         mean_act;

  logic                   s1_valid;
  logic [DW-1:0]          s1_m;
  logic [NCH-1:0][EW-1:0] s1_err;
  logic [NCH-1:0]         s1_act;
  logic                   adv, take;

  tdc_mean #(.TW(TW)) u_mean (
    .temp  (in_temp),
    .fault (in_fault),
    .err   (mean_err),
    .act   (mean_act)
  );

  assign adv      = s1_valid && (!out_valid || out_ready);
  assign in_ready = !s1_valid || adv;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_m      <= '0;
      s1_err    <= '0;
      s1_act    <= '0;
      out_valid <= 1'b0;
    end else begin
      if (take) begin
        s1_m   <= in_duty;
        s1_err <= mean_err;
        s1_act <= mean_act;
      end
      s1_valid <= take || (s1_valid && !adv);
      if (adv)            out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      tdc_pi_chan #(.EW(EW), .DW(DW), .AW(AW), .KP(KP), .KI(KI)) u_pi (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (adv),
        .act    (s1_act[g]),
        .ref_in (s1_m),
        .err    (s1_err[g]),
        .duty   (out_duty[g*DW +: DW])
      );
    end
  endgenerate
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker
  import tdc_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NCH*DW-1:0] out_duty,
  input logic              adv,
  input logic [NCH-1:0]    s1_act,
  input logic [DW-1:0]     s1_m
);
  localparam logic [DW-1:0] ONE_D = DW'(64'd1 << (DW-1));

  // R7: a stalled result is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_duty)));

  // R8: a result waiting in the first register reaches the output on the next edge
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> out_valid);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_lane
      // R5: lane never exceeds full scale
      p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_duty[g*DW +: DW] <= ONE_D);

      // R4: a faulted module passes the clamped common reference
      p_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adv) && !$past(s1_act[g])) |->
          (out_duty[g*DW +: DW] == (($past(s1_m) > ONE_D) ? ONE_D : $past(s1_m))));
    end
  endgenerate
endmodule

bind thermal_duty_corrector tdc_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_duty  (out_duty),
  .adv       (adv),
  .s1_act    (s1_act),
  .s1_m      (s1_m)
);

// File: tb/thermal_duty_corrector_test.sv
module thermal_duty_corrector_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW  = 12;
  localparam int DW  = 16;
  localparam int KP  = 4;
  localparam int KI  = 1;
  localparam int ONE = 32768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_duty = '0;
  logic [4*TW-1:0] in_temp = '0;
  logic [3:0] in_fault = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [4*DW-1:0] out_duty;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [4*DW-1:0] exp_q[$];
  int              mq[$];
  string           tag_q[$];
  int              integ_m[4] = '{0, 0, 0, 0};

  logic            stall_prev = 1'b0;
  logic [4*DW-1:0] hold_data = '0;

  thermal_duty_corrector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_duty(in_duty), .in_temp(in_temp), .in_fault(in_fault),
    .out_valid(out_valid), .out_ready(out_ready), .out_duty(out_duty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (bp_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
  end

  task automatic check(input bit ok, input string req, input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic send(input int m, input int ta, input int tb, input int tc, input int td,
                      input logic [3:0] flt, input string tag);
    int t[4];
    int sum, cnt, mean, e, ic, raw, ev;
    logic [4*DW-1:0] expv;
    t[0] = ta; t[1] = tb; t[2] = tc; t[3] = td;
    sum = 0; cnt = 0;
    for (int i = 0; i < 4; i++) if (!flt[i]) begin sum += t[i]; cnt++; end
    mean = (cnt == 0) ? 0 : sum / cnt;
    for (int i = 0; i < 4; i++) begin
      if (flt[i]) begin
        integ_m[i] = 0;
        ev = (m > ONE) ? ONE : m;
      end else begin
        e = mean - t[i];
        ic = integ_m[i] + KI * e;
        if (ic > ONE) ic = ONE;
        if (ic < -ONE) ic = -ONE;
        raw = m + KP * e + ic;
        if (raw >= 0 && raw <= ONE) integ_m[i] = ic;
        ev = (raw < 0) ? 0 : ((raw > ONE) ? ONE : raw);
      end
      expv[i*DW +: DW] = DW'(ev);
    end
    exp_q.push_back(expv);
    mq.push_back(m);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_duty  = DW'(m);
    in_temp  = {TW'(td), TW'(tc), TW'(tb), TW'(ta)};
    in_fault = flt;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stall_prev)
        check(out_valid === 1'b1 && out_duty === hold_data, "R7 stall hold",
              int'(out_duty[15:0]), int'(hold_data[15:0]));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", 1, 0);
        end else begin
          logic [4*DW-1:0] ex;
          int m, lsum;
          string tg;
          ex = exp_q.pop_front();
          m  = mq.pop_front();
          tg = tag_q.pop_front();
          lsum = 0;
          for (int i = 0; i < 4; i++) begin
            check(out_duty[i*DW +: DW] === ex[i*DW +: DW], {tg, " lane"},
                  int'(out_duty[i*DW +: DW]), int'(ex[i*DW +: DW]));
            lsum += int'(out_duty[i*DW +: DW]);
          end
          if (tg == "R3") check(lsum == 4 * m, "R3 zero-sum", lsum, 4 * m);
        end
      end
      stall_prev = out_valid && !out_ready;
      hold_data  = out_duty;
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: got 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(out_valid === 1'b0, "R9 out_valid", int'(out_valid), 0);
    check(in_ready === 1'b1, "R9 in_ready", int'(in_ready), 1);
    check(out_duty === '0, "R9 out_duty", int'(out_duty[15:0]), 0);

    // R8 latency: accepted at edge k, valid after k+1
    send(16384, 300, 300, 300, 300, 4'b0000, "R2");
    @(negedge clk);
    check(out_valid === 1'b0, "R8 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid === 1'b1, "R8 valid after second edge", int'(out_valid), 1);

    // R2/R3 spread, integrator builds up
    for (int k = 0; k < 4; k++) send(16384, 310, 300, 290, 300, 4'b0000, "R3");
    send(20000, 320, 280, 305, 295, 4'b0000, "R3");
    // R1 floor of uneven mean
    send(16384, 301, 300, 300, 300, 4'b0000, "R1");
    // R1/R4 one faulted: divide by 3
    send(16384, 300, 300, 900, 330, 4'b0100, "R4");
    send(16384, 300, 300, 900, 330, 4'b0100, "R1");
    // R4 fault removed: lane 2 restarts from zero integrator
    send(16384, 300, 300, 300, 300, 4'b0000, "R4");
    // R1 two faulted: divide by 2
    send(10000, 350, 999, 301, 0, 4'b1010, "R1");
    // R4 all faulted, m above full scale
    send(40000, 300, 310, 320, 330, 4'b1111, "R4");
    // R5 m above full scale, equal temps
    send(40000, 300, 300, 300, 300, 4'b0000, "R5");
    // R5/R6 saturation high and low
    send(32600, 300, 300, 300, 400, 4'b0000, "R6");
    send(32600, 300, 300, 300, 400, 4'b0000, "R6");
    send(30, 400, 300, 300, 300, 4'b0000, "R5");
    send(16384, 300, 300, 300, 300, 4'b0000, "R6");

    // R7 random back-pressure with a burst of samples
    bp_mode = 1;
    for (int k = 0; k < 24; k++)
      send(8000 + 500 * k, 300 + k, 300 - k, 310, 290 + (k % 5), (k % 7 == 3) ? 4'b0001 : 4'b0000, "R7");
    bp_mode = 0;

    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule